// File: doc/BRIEF.md
# System Control Register Bank with Access Legality Check

This block holds the system control words of a processor's control coprocessor and decides, for every access, whether that access is allowed. An access carries a primary register number, a secondary register number, two opcode fields, a privilege flag, a direction strobe and write data. The legality decision is combinational. The block answers in the same cycle with either a done pulse or an undefined-instruction response.

Storage is two banks of sixteen words. The bank is chosen by the second opcode field: a value of zero picks the primary bank, and any other value picks the alternate bank. A legal write lands on the next rising clock edge. A rejected access changes nothing. Reset clears every word and then loads fixed identification, cache-type and control values.

Top module: `sysctl_regbank`

## Requirements
- R1: An access with `acc_user` high is rejected (`acc_undef`=1, `acc_done`=0), whatever the other fields are.
- R2: An access with a non-zero `acc_op1` is rejected.
- R3: Registers 0 and 1 accept `acc_crm`=0 with any `acc_op2`. `acc_op2`=0 addresses the primary bank and a non-zero value addresses the alternate bank; a word written through one bank is not visible through the other.
- R4: Registers 2, 3, 5, 6 and 13 accept only `acc_crm`=0 with `acc_op2`=0.
- R5: Registers 4, 11 and 12 reject every access.
- R6: Register 7 accepts exactly these (`acc_op2`, `acc_crm`) pairs: (0,5) (0,6) (0,7) (1,5) (1,6) (1,10) (4,10) (5,2) (6,5).
- R7: Register 8 accepts `acc_op2` of 0 with `acc_crm` of 5, 6 or 7, and `acc_op2` of 1 with `acc_crm` of 5 or 6.
- R8: Register 14 accepts `acc_op2`=0 with `acc_crm` in {0,3,4,8,9}. Register 15 accepts only `acc_op2`=0 with `acc_crm`=1.
- R9: After reset every word reads zero, except primary register 0 = 0x69050000, alternate register 0 = 0x0B1AA1AA and primary register 1 = 0x00000078.
- R10: When `acc_valid` is high, exactly one of `acc_done`/`acc_undef` is high in the same cycle. When it is low, both are low.
- R11: A legal write stores `acc_wdata` at the next rising edge. A rejected write leaves both banks unchanged.
- R12: A legal read returns the addressed word of the selected bank in the same cycle. `acc_rdata` is zero for rejected accesses, for writes and when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_user | input | 1 | 1 = issued from unprivileged user mode |
| acc_crn | input | 4 | Primary register number |
| acc_crm | input | 4 | Secondary register number |
| acc_op1 | input | 3 | First opcode field, must be zero |
| acc_op2 | input | 3 | Second opcode field, selects bank |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data |
| acc_done | output | 1 | Access accepted |
| acc_undef | output | 1 | Access rejected as undefined |

## Verification
The bench first reads the reset image through both banks. It then sweeps every combination of primary register, secondary register and second opcode as a privileged write followed by a read. This separates each entry of the irregular legality table from its neighbours. It also shows that rejected writes leave the storage untouched, and that the two banks stay apart. Further passes repeat legal encodings with the user flag set, with a non-zero first opcode, and with `acc_valid` low. These passes show that privilege and the first opcode override an otherwise legal encoding.

// File: rtl/sysctl_regbank.sv
module sysctl_regbank #(
  parameter int          DW         = 32,
  parameter logic [31:0] ID_INIT    = 32'h6905_0000,
  parameter logic [31:0] CTYPE_INIT = 32'h0B1A_A1AA,
  parameter logic [31:0] CTRL_INIT  = 32'h0000_0078
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic          acc_user,
  input  logic [3:0]    acc_crn,
  input  logic [3:0]    acc_crm,
  input  logic [2:0]    acc_op1,
  input  logic [2:0]    acc_op2,
  input  logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] acc_rdata,
  output logic          acc_done,
  output logic          acc_undef
);
  localparam int NREG = 16;

  logic [NREG-1:0][DW-1:0] bank_lo, bank_hi;
  logic [15:0] crm_ok;
  logic        legal, hi_sel;
  logic [DW-1:0] word;

  always_comb begin
    crm_ok = '0;
    case (acc_crn)
      4'd0, 4'd1:                    crm_ok = 16'h0001;
      4'd2, 4'd3, 4'd5, 4'd6, 4'd13: crm_ok = (acc_op2 == 3'd0) ? 16'h0001 : 16'h0000;
      4'd7:
        case (acc_op2)
          3'd0:    crm_ok = 16'h00E0;
          3'd1:    crm_ok = 16'h0460;
          3'd4:    crm_ok = 16'h0400;
          3'd5:    crm_ok = 16'h0004;
          3'd6:    crm_ok = 16'h0020;
          default: crm_ok = 16'h0000;
        endcase
      4'd8:
        case (acc_op2)
          3'd0:    crm_ok = 16'h00E0;
          3'd1:    crm_ok = 16'h0060;
          default: crm_ok = 16'h0000;
        endcase
      4'd14: crm_ok = (acc_op2 == 3'd0) ? 16'h0319 : 16'h0000;
      4'd15: crm_ok = (acc_op2 == 3'd0) ? 16'h0002 : 16'h0000;
      default: crm_ok = 16'h0000;
    endcase
  end

  assign legal     = acc_valid && !acc_user && (acc_op1 == 3'd0) && crm_ok[acc_crm];
  assign acc_done  = legal;
  assign acc_undef = acc_valid && !legal;
  assign hi_sel    = |acc_op2;
  assign word      = hi_sel ? bank_hi[acc_crn] : bank_lo[acc_crn];
  assign acc_rdata = (legal && !acc_write) ? word : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_lo    <= '0;
      bank_hi    <= '0;
      bank_lo[0] <= ID_INIT;
      bank_hi[0] <= CTYPE_INIT;
      bank_lo[1] <= CTRL_INIT;
    end else if (legal && acc_write) begin
      if (hi_sel) bank_hi[acc_crn] <= acc_wdata;
      else        bank_lo[acc_crn] <= acc_wdata;
    end
  end

  AST_USER_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_user |-> acc_undef && !acc_done); // R1
  AST_OP1_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && (acc_op1 != 3'd0) |-> acc_undef); // R2
  AST_DEAD_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && (acc_crn == 4'd4 || acc_crn == 4'd11 || acc_crn == 4'd12) |-> acc_undef); // R5
  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> $onehot({acc_done, acc_undef})); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !acc_done && !acc_undef && acc_rdata == '0); // R10
  AST_UNDEF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_undef |=> $stable(bank_lo) && $stable(bank_hi)); // R11
  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc_undef |-> acc_rdata == '0); // R12
endmodule

// File: tb/sysctl_regbank_bench.sv
module sysctl_regbank_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        acc_valid = 0, acc_write = 0, acc_user = 0;
  logic [3:0]  acc_crn = 0, acc_crm = 0;
  logic [2:0]  acc_op1 = 0, acc_op2 = 0;
  logic [31:0] acc_wdata = 0;
  logic [31:0] acc_rdata;
  logic        acc_done, acc_undef;

  int compared = 0, mismatched = 0;
  int unsigned mem [2][16];

  always #5 clk = ~clk;

  sysctl_regbank u_sysctl_regbank (.*);

  function automatic bit ref_legal(int crn, int crm, int op2);
    if (crn == 0 || crn == 1) return crm == 0;
    if (crn inside {2, 3, 5, 6, 13}) return crm == 0 && op2 == 0;
    if (crn == 7) return (op2 == 0 && crm >= 5 && crm <= 7) ||
                         (op2 == 1 && (crm == 5 || crm == 6 || crm == 10)) ||
                         (op2 == 4 && crm == 10) || (op2 == 5 && crm == 2) ||
                         (op2 == 6 && crm == 5);
    if (crn == 8) return (op2 == 0 && crm >= 5 && crm <= 7) ||
                         (op2 == 1 && (crm == 5 || crm == 6));
    if (crn == 14) return op2 == 0 && crm inside {0, 3, 4, 8, 9};
    if (crn == 15) return op2 == 0 && crm == 1;
    return 0;
  endfunction

  function automatic string tag_of(int crn);
    if (crn <= 1) return "R3";
    if (crn == 7) return "R6";
    if (crn == 8) return "R7";
    if (crn >= 14) return "R8";
    if (crn inside {4, 11, 12}) return "R5";
    return "R4";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h (crn=%0d crm=%0d op1=%0d op2=%0d user=%0b wr=%0b)",
               tag, act, exp, acc_crn, acc_crm, acc_op1, acc_op2, acc_user, acc_write);
    end
  endtask

  task automatic access(bit v, bit wr, bit usr, int crn, int crm, int op1, int op2,
                        logic [31:0] wd, string tag);
    bit ok;
    logic [31:0] exp_rd;
    @(negedge clk);
    acc_valid = v; acc_write = wr; acc_user = usr;
    acc_crn = crn[3:0]; acc_crm = crm[3:0]; acc_op1 = op1[2:0]; acc_op2 = op2[2:0];
    acc_wdata = wd;
    ok = v && !usr && op1 == 0 && ref_legal(crn, crm, op2);
    exp_rd = (ok && !wr) ? mem[op2 != 0][crn] : 32'h0;
    #2;
    check(tag, {30'h0, acc_done, acc_undef}, {30'h0, ok, v && !ok});
    check(ok ? "R12" : tag, acc_rdata, exp_rd);
    @(posedge clk);
    if (ok && wr) mem[op2 != 0][crn] = wd;
  endtask

  initial begin
    #(2_000_000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    foreach (mem[b, r]) mem[b][r] = 0;
    mem[0][0] = 32'h6905_0000;
    mem[1][0] = 32'h0B1A_A1AA;
    mem[0][1] = 32'h0000_0078;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset image through both banks
    access(1, 0, 0, 0, 0, 0, 0, 0, "R9");
    access(1, 0, 0, 0, 0, 0, 5, 0, "R9");
    access(1, 0, 0, 1, 0, 0, 0, 0, "R9");
    access(1, 0, 0, 1, 0, 0, 2, 0, "R9");
    access(1, 0, 0, 2, 0, 0, 0, 0, "R9");
    // R10 idle
    access(0, 1, 0, 2, 0, 0, 0, 32'hFFFF_FFFF, "R10");
    // R1 user mode and R2 op1 on legal encodings
    access(1, 1, 1, 2, 0, 0, 0, 32'hDEAD_0001, "R1");
    access(1, 0, 1, 0, 0, 0, 0, 0, "R1");
    access(1, 1, 0, 3, 0, 1, 0, 32'hDEAD_0002, "R2");
    access(1, 0, 0, 1, 0, 7, 0, 0, "R2");
    access(1, 0, 0, 2, 0, 0, 0, 0, "R11");
    access(1, 0, 0, 3, 0, 0, 0, 0, "R11");
    // exhaustive sweep: write then read every encoding (R3..R8, R11, R12)
    for (int crn = 0; crn < 16; crn++)
      for (int crm = 0; crm < 16; crm++)
        for (int op2 = 0; op2 < 8; op2++) begin
          access(1, 1, 0, crn, crm, 0, op2, {crn[3:0], crm[3:0], op2[7:0], 16'hA5C3} ^ compared, tag_of(crn));
          access(1, 0, 0, crn, crm, 0, op2, 0, tag_of(crn));
        end
    // R3 bank separation read-back
    access(1, 0, 0, 0, 0, 0, 0, 0, "R3");
    access(1, 0, 0, 0, 0, 0, 1, 0, "R3");
    access(1, 0, 0, 1, 0, 0, 0, 0, "R3");
    access(1, 0, 0, 1, 0, 0, 7, 0, "R3");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule